// File: doc/BRIEF.md
# Sequential Signed Booth Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits (default 4) over several clocks, using radix-2 Booth recoding. A one-cycle `start` while the block is idle captures both operands. From then on, each clock performs one step, and the choice of action in that step comes from the current low multiplier bit and the bit that was shifted out below it:

- pairs `00` and `11` leave the accumulator alone;
- pair `01` adds the multiplicand to the accumulator;
- pair `10` subtracts the multiplicand from the accumulator.

After that action, the joint accumulator/multiplier/extension register shifts one place to the right, arithmetically. After exactly `WIDTH` steps, the `2*WIDTH`-bit signed product is registered on `product` and `done` pulses for one clock.

Negative operands need no sign correction, because the shift keeps the sign of the accumulator. The accumulator has one guard bit above `WIDTH`, so adding or subtracting the most negative multiplicand cannot wrap. The product register keeps its value until the next operation completes. A `start` seen while the block is working has no effect.

Top module: `booth_seq_mult`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `busy`, `done` and `product` are all zero.
- R2: A high `start` sampled while `busy` is low captures `multiplicand` and `multiplier`, and `busy` is high from the next cycle.
- R3: Completion is signalled in the cycle after `busy` has been high for exactly `WIDTH` cycles. In that cycle `done` is high and `busy` is low.
- R4: When `done` is high, `product` equals the signed product of the captured operands as a `2*WIDTH`-bit two's-complement value. This holds for every sign combination and for the most negative value of either operand, for example 7 × 3 at `WIDTH`=4 gives 0x15.
- R5: `done` is high for exactly one cycle per operation.
- R6: `product` changes only in a cycle where `done` is high, and holds its value otherwise.
- R7: A `start` sampled while `busy` is high is ignored. Neither the result nor the completion timing of the running operation is affected by it, or by operand changes while busy.
- R8: Behaviour R2 to R7 also holds at a wider `WIDTH` (12 here), including the most negative times itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication when idle |
| multiplicand | input | WIDTH | Signed multiplicand |
| multiplier | input | WIDTH | Signed multiplier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2*WIDTH | Signed product, held between completions |

## Verification
Every one of the 256 operand pairs at width 4 is applied. This covers all recode pair sequences, including runs of ones, alternating bits and both signs. The most negative operand on either side separates a guarded accumulator from one that wraps. A 12-bit instance runs in parallel, fed with the extreme values and with random pairs, to show that the step count and datapath scale with the parameter. Restarts and operand changes are injected in the middle of an operation; they separate a control that really ignores `start` from one that reloads or changes its timing.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_ADD  = 2'd1,
    STEP_SUB  = 2'd2
  } step_op_t;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic     lsb,
  input  logic     prev_lsb,
  output step_op_t op
);
  always_comb begin
    unique case ({lsb, prev_lsb})
      2'b01:   op = STEP_ADD;
      2'b10:   op = STEP_SUB;
      default: op = STEP_HOLD;
    endcase
  end
endmodule

// File: rtl/booth_step.sv
module booth_step
  import booth_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH:0]   acc,
  input  logic [WIDTH-1:0] mq,
  input  logic             ext,
  input  logic [WIDTH-1:0] mcand,
  input  step_op_t         op,
  output logic [WIDTH:0]   acc_nx,
  output logic [WIDTH-1:0] mq_nx,
  output logic             ext_nx
);
  localparam int AW = WIDTH + 1;

  logic [AW-1:0] m_ext;
  logic [AW-1:0] sum;

  assign m_ext = {mcand[WIDTH-1], mcand};

  always_comb begin
    unique case (op)
      STEP_ADD: sum = acc + m_ext;
      STEP_SUB: sum = acc - m_ext;
      default:  sum = acc;
    endcase
  end

  assign acc_nx = {sum[AW-1], sum[AW-1:1]};
  assign mq_nx  = {sum[0], mq[WIDTH-1:1]};
  assign ext_nx = mq[0];
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int WIDTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done,
  output logic load,
  output logic last
);
  localparam int CW = $clog2(WIDTH + 1);

  logic [CW-1:0] cnt;

  assign load = start && !busy;
  assign last = busy && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (start) begin
        busy <= 1'b1;
        cnt  <= CW'(WIDTH);
      end
    end
  end

  assert_start_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_finish_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != CW'(1)) |=> (busy && !done));
endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
  import booth_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [WIDTH-1:0]     multiplicand,
  input  logic [WIDTH-1:0]     multiplier,
  output logic                 busy,
  output logic                 done,
  output logic [2*WIDTH-1:0]   product
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH:0]   acc_q, acc_nx;
  logic [WIDTH-1:0] mq_q, mq_nx;
  logic [WIDTH-1:0] mcand_q;
  logic             ext_q, ext_nx;
  logic             load, last;
  step_op_t         op;

  booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .busy(busy), .done(done), .load(load), .last(last)
  );

  booth_recode u_recode (
    .lsb(mq_q[0]), .prev_lsb(ext_q), .op(op)
  );

  booth_step #(.WIDTH(WIDTH)) u_step (
    .acc(acc_q), .mq(mq_q), .ext(ext_q), .mcand(mcand_q), .op(op),
    .acc_nx(acc_nx), .mq_nx(mq_nx), .ext_nx(ext_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      mq_q    <= '0;
      ext_q   <= 1'b0;
      mcand_q <= '0;
      product <= '0;
    end else if (load) begin
      acc_q   <= '0;
      mq_q    <= multiplier;
      ext_q   <= 1'b0;
      mcand_q <= multiplicand;
    end else if (busy) begin
      acc_q <= acc_nx;
      mq_q  <= mq_nx;
      ext_q <= ext_nx;
      if (last) product <= PW'({acc_nx[WIDTH-1:0], mq_nx});
    end
  end

  assert_product_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(product));
endmodule

// File: tb/booth_seq_mult_test.sv
module booth_lane_check #(
  parameter int W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic             busy,
  input  logic             done,
  input  logic [2*W-1:0]   product,
  output int               checks,
  output int               errors
);
  bit           m_busy, m_done;
  int           m_cnt;
  longint       m_a, m_b;
  logic [2*W-1:0] m_prod;
  longint       full;

  initial begin
    checks = 0; errors = 0;
    m_busy = 0; m_done = 0; m_cnt = 0; m_prod = '0; m_a = 0; m_b = 0;
  end

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_cnt = 0; m_prod = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1;
          full = m_a * m_b;
          m_prod = full[2*W-1:0];
        end
      end else if (start) begin
        m_busy = 1; m_cnt = W;
        m_a = longint'($signed(a));
        m_b = longint'($signed(b));
      end
    end
    #2;
    checks += 3;
    if (busy !== m_busy) begin
      errors++;
      $display("FAIL R3 (W=%0d) busy act=%0b exp=%0b", W, busy, m_busy);
    end
    if (done !== m_done) begin
      errors++;
      $display("FAIL R5 (W=%0d) done act=%0b exp=%0b", W, done, m_done);
    end
    if (product !== m_prod) begin
      errors++;
      if (W != 4)
        $display("FAIL R8 product act=%h exp=%h", product, m_prod);
      else if (m_done)
        $display("FAIL R4 product act=%h exp=%h", product, m_prod);
      else
        $display("FAIL R6 held product act=%h exp=%h", product, m_prod);
    end
  end
endmodule

module booth_seq_mult_test;
  localparam int NA = 4;
  localparam int NB = 12;

  logic clk = 0;
  logic rst = 1;
  logic start = 0;
  logic [NA-1:0] a4 = '0, b4 = '0;
  logic [NB-1:0] a12 = '0, b12 = '0;
  logic busy4, done4, busy12, done12;
  logic [2*NA-1:0] prod4;
  logic [2*NB-1:0] prod12;
  int c4, e4, c12, e12;
  int own_checks = 0, own_errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  booth_seq_mult #(.WIDTH(NA)) uut (
    .clk(clk), .rst(rst), .start(start), .multiplicand(a4), .multiplier(b4),
    .busy(busy4), .done(done4), .product(prod4)
  );
  booth_seq_mult #(.WIDTH(NB)) uut_wide (
    .clk(clk), .rst(rst), .start(start), .multiplicand(a12), .multiplier(b12),
    .busy(busy12), .done(done12), .product(prod12)
  );

  booth_lane_check #(.W(NA)) chk4 (
    .clk(clk), .rst(rst), .start(start), .a(a4), .b(b4),
    .busy(busy4), .done(done4), .product(prod4), .checks(c4), .errors(e4)
  );
  booth_lane_check #(.W(NB)) chk12 (
    .clk(clk), .rst(rst), .start(start), .a(a12), .b(b12),
    .busy(busy12), .done(done12), .product(prod12), .checks(c12), .errors(e12)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors",
             own_checks + c4 + c12, own_errors + e4 + e12);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      own_checks++; own_errors++;
      $display("FAIL watchdog expired act=%0d exp<=150000", cycles);
      summary();
    end
  end

  // one operation on both lanes; disturb = inject ignored starts (R7)
  task automatic run_op(input logic [NA-1:0] x4, input logic [NA-1:0] y4,
                        input logic [NB-1:0] x12, input logic [NB-1:0] y12,
                        input bit disturb);
    @(negedge clk);
    a4 = x4; b4 = y4; a12 = x12; b12 = y12; start = 1;
    @(negedge clk);
    start = 0;
    if (disturb) begin
      a4 = ~x4; b4 = x4; a12 = ~x12; b12 = 12'h800;
      start = 1;   // R7: both busy here, must be ignored
      @(negedge clk);
      start = 0;
      @(negedge clk);
      a4 = 4'h8; start = 1;
      @(negedge clk);
      start = 0;
    end
    while (busy4 || busy12) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    own_checks++;
    if (busy4 !== 0 || done4 !== 0 || prod4 !== '0 || prod12 !== '0) begin
      own_errors++;
      $display("FAIL R1 reset act=%0b%0b %h exp=00 00", busy4, done4, prod4);
    end
    rst = 0;
    @(negedge clk);
    own_checks++;
    if (busy12 !== 0 || done12 !== 0 || prod12 !== '0) begin
      own_errors++;
      $display("FAIL R1 after reset act=%0b%0b %h exp=00 0", busy12, done12, prod12);
    end
    // R4 named case: 7 x 3 = 0x15
    run_op(4'd7, 4'd3, 12'd7, 12'd3, 0);
    @(negedge clk);
    own_checks++;
    if (prod4 !== 8'h15) begin
      own_errors++;
      $display("FAIL R4 7x3 act=%h exp=15", prod4);
    end
    // R8 wide extremes
    run_op(4'h8, 4'h8, 12'h800, 12'h800, 0);
    own_checks++;
    if (prod12 !== 24'h400000) begin
      own_errors++;
      $display("FAIL R8 min*min act=%h exp=400000", prod12);
    end
    run_op(4'h8, 4'h7, 12'h800, 12'h7FF, 1);
    run_op(4'hF, 4'h8, 12'hFFF, 12'h800, 1);
    // R4 exhaustive narrow, R8 random wide, R7 disturbance on some
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        run_op(NA'(i), NA'(j), NB'($urandom), NB'($urandom), ((i + j) % 5) == 0);
      end
    end
    repeat (3) @(negedge clk);
    summary();
  end
endmodule